// File: doc/BRIEF.md
# Latency-Insensitive Shell Wrapper

This block wraps a stallable synchronous core so that it can sit on channels whose latency is not known when the core is designed. Every external channel carries a valid bit and a data word forward and a stop bit backward. Words reaching the inputs at different times are held in small per-channel buffers. A complete set, one word from every input, is handed to the core in a single cycle. Each core output feeds a two-word buffer, so downstream stop never reaches the core directly.

When any output buffer is about to become full, a stall request forces a void onto every core input in that same cycle. A stallable core answers a void input by holding its state and producing a void output one cycle later, so that buffer never overflows. Whatever gaps appear upstream and whatever stop patterns come from downstream, each output carries exactly the sequence of words the bare core would have produced with all words arriving at once.

The wrapped core here is an accumulator with a hold enable. It has one input channel per operand. Output 0 carries the running sum of all operands, and output 1 carries the XOR of the current operand set.

Top module: `li_shell_wrapper`

## Requirements
- R1: While reset is asserted, and after it until the first word is accepted, every `out_valid_o` bit is 0. Every `in_stop_o` bit is 0 until its channel holds words.
- R2: An input word is taken at a rising edge where its `in_valid_i` bit is 1 and its `in_stop_o` bit is 0. Each input channel buffers up to two words. Its `in_stop_o` bit is 1 exactly while two words are held, and it depends only on stored state.
- R3: The core is fired only in a cycle where every input buffer holds a word and the stall request is 0. Each firing removes one word from every input buffer. Words on a single channel alone never produce a result.
- R4: Output channel 0 carries the running sum, modulo 2^W, of all words of all sets fired so far. Output channel 1 carries the XOR of the words of the current set. A core cycle with void input keeps the sum unchanged and yields no result in the following cycle.
- R5: Each output channel has a two-word buffer. Its full flag is 1 in a cycle when the words held after that cycle's incoming and outgoing transfers would number two.
- R6: The stall request is the OR of all output full flags, and no set is fired while it is 1. If output 0 is stopped indefinitely from an empty state while all inputs stream, each input accepts exactly four words, output 1 emits exactly two results, and every `in_stop_o` bit ends at 1.
- R7: An output whose valid is 1 while its stop is 1 keeps valid at 1 and data unchanged in the next cycle.
- R8: Under any pattern of input gaps and output stops, each output emits the same word sequence as a zero-latency run of the core on the same input sets, with nothing lost or repeated.
- R9: With every input valid in every cycle and no stops, each output emits one result per cycle once the pipeline is filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_IN | Per input channel: a word is present |
| in_data_i | input | N_IN*W | Per input channel: data word |
| in_stop_o | output | N_IN | Per input channel: buffer full, hold the word |
| out_valid_o | output | 2 | Per output channel: a result is present |
| out_data_o | output | 2*W | Per output channel: result word |
| out_stop_i | input | 2 | Per output channel: downstream cannot take a word |

## Verification
Two events can fall into one cycle and interact: a new core result entering an output buffer and a word leaving that buffer under a stop that has just been released. Together they decide whether the full flag rises, and so whether the next input set may fire. The bench provokes this with long runs of random input voids and random downstream stops, and with a phase where one output is held stopped while the other drains. A behavioural model builds operand sets from queues and compares every transferred result against it. The bench also checks the number of words accepted per input and emitted per output when one output is blocked.

// File: rtl/li_pkg.sv
package li_pkg;
  localparam int unsigned LI_OUTS   = 2;
  localparam int unsigned BUF_DEPTH = 2;
  typedef enum int unsigned {
    CH_SUM = 0,
    CH_XOR = 1
  } li_out_ch_e;
endpackage

// File: rtl/li_relay_buf.sv
module li_relay_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic [1:0]   cnt_o
);
  logic [1:0][W-1:0] slot_q;
  logic              rd_q, wr_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= data_i;
        wr_q         <= ~wr_q;
      end
      if (pop_i) rd_q <= ~rd_q;
      cnt_q <= cnt_q + {1'b0, push_i} - {1'b0, pop_i};
    end
  end

  assign valid_o = (cnt_q != 2'd0);
  assign data_o  = slot_q[rd_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/li_equalizer.sv
module li_equalizer #(
  parameter int unsigned N_IN = 2,
  parameter int unsigned W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_IN-1:0]           in_valid_i,
  input  logic [N_IN-1:0][W-1:0]    in_data_i,
  output logic [N_IN-1:0]           in_stop_o,
  input  logic                      stall_i,
  output logic                      fire_o,
  output logic [N_IN-1:0][W-1:0]    core_data_o
);
  logic [N_IN-1:0]      avail;
  logic [N_IN-1:0][1:0] cnt;

  // fire only with a complete set and no pending stall
  assign fire_o = (&avail) & ~stall_i;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign in_stop_o[i] = (cnt[i] == 2'(li_pkg::BUF_DEPTH));
    li_relay_buf #(.W(W)) i_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[i] & ~in_stop_o[i]),
      .data_i  (in_data_i[i]),
      .pop_i   (fire_o),
      .valid_o (avail[i]),
      .data_o  (core_data_o[i]),
      .cnt_o   (cnt[i])
    );
  end
endmodule

// File: rtl/li_ext_relay.sv
module li_ext_relay #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         stop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic [1:0] cnt;
  logic [2:0] occ_nxt;
  logic       pop;

  assign pop     = valid_o & ~stop_i;
  assign occ_nxt = {1'b0, cnt} + {2'b0, push_i} - {2'b0, pop};
  // look-ahead flag: core sees the stall before the next result can land
  assign full_o  = (occ_nxt == 3'(li_pkg::BUF_DEPTH));

  li_relay_buf #(.W(W)) i_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .data_i  (data_i),
    .pop_i   (pop),
    .valid_o (valid_o),
    .data_o  (data_o),
    .cnt_o   (cnt)
  );
endmodule

// File: rtl/li_accum_core.sv
module li_accum_core #(
  parameter int unsigned N_IN = 2,
  parameter int unsigned W    = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 en_i,
  input  logic [N_IN-1:0][W-1:0]               data_i,
  output logic                                 vld_o,
  output logic [li_pkg::LI_OUTS-1:0][W-1:0]    res_o
);
  logic [W-1:0] acc_q, sum_c, xor_c;
  logic         vld_q;
  logic [li_pkg::LI_OUTS-1:0][W-1:0] res_q;

  always_comb begin
    sum_c = acc_q;
    xor_c = '0;
    for (int i = 0; i < N_IN; i++) begin
      sum_c = sum_c + data_i[i];
      xor_c = xor_c ^ data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= en_i;
      if (en_i) begin
        acc_q               <= sum_c;
        res_q[li_pkg::CH_SUM] <= sum_c;
        res_q[li_pkg::CH_XOR] <= xor_c;
      end
    end
  end

  assign vld_o = vld_q;
  assign res_o = res_q;
endmodule

// File: rtl/li_shell_wrapper.sv
module li_shell_wrapper #(
  parameter int unsigned N_IN = 2,
  parameter int unsigned W    = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [N_IN-1:0]                      in_valid_i,
  input  logic [N_IN-1:0][W-1:0]               in_data_i,
  output logic [N_IN-1:0]                      in_stop_o,
  output logic [li_pkg::LI_OUTS-1:0]           out_valid_o,
  output logic [li_pkg::LI_OUTS-1:0][W-1:0]    out_data_o,
  input  logic [li_pkg::LI_OUTS-1:0]           out_stop_i
);
  localparam int unsigned NO = li_pkg::LI_OUTS;

  logic                  stall;
  logic                  core_en;
  logic                  core_vld;
  logic [N_IN-1:0][W-1:0] core_din;
  logic [NO-1:0][W-1:0]  core_res;
  logic [NO-1:0]         ers_full;

  assign stall = |ers_full;

  li_equalizer #(.N_IN(N_IN), .W(W)) i_eq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_stop_o   (in_stop_o),
    .stall_i     (stall),
    .fire_o      (core_en),
    .core_data_o (core_din)
  );

  li_accum_core #(.N_IN(N_IN), .W(W)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (core_en),
    .data_i (core_din),
    .vld_o  (core_vld),
    .res_o  (core_res)
  );

  for (genvar j = 0; j < NO; j++) begin : g_out
    li_ext_relay #(.W(W)) i_ers (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (core_vld),
      .data_i  (core_res[j]),
      .stop_i  (out_stop_i[j]),
      .valid_o (out_valid_o[j]),
      .data_o  (out_data_o[j]),
      .full_o  (ers_full[j])
    );
  end
endmodule

// File: rtl/li_shell_chk.sv
module li_shell_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned NO = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  core_en_i,
  input logic                  core_vld_i,
  input logic [NO-1:0]         ers_full_i,
  input logic [NO-1:0]         out_valid_i,
  input logic [NO-1:0]         out_stop_i,
  input logic [NO-1:0][W-1:0]  out_data_i
);
  // R4
  void_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_en_i |=> !core_vld_i);

  // R4
  fire_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_i |=> core_vld_i);

  // R6
  flag_void_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ers_full_i) |=> !core_vld_i);

  for (genvar j = 0; j < NO; j++) begin : g_hold
    // R7
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_i[j] && out_stop_i[j]) |=> (out_valid_i[j] && $stable(out_data_i[j])));
  end
endmodule

bind li_shell_wrapper li_shell_chk #(.W(W), .NO(li_pkg::LI_OUTS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .core_en_i   (core_en),
  .core_vld_i  (core_vld),
  .ers_full_i  (ers_full),
  .out_valid_i (out_valid_o),
  .out_stop_i  (out_stop_i),
  .out_data_i  (out_data_o)
);

// File: tb/test_li_shell_wrapper.sv
`timescale 1ns/1ps
module test_li_shell_wrapper;
  localparam int unsigned N_IN = 2;
  localparam int unsigned W    = 8;
  localparam int unsigned NO   = 2;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [N_IN-1:0]        in_valid_i = '0;
  logic [N_IN-1:0][W-1:0] in_data_i = '0;
  logic [N_IN-1:0]        in_stop_o;
  logic [NO-1:0]          out_valid_o;
  logic [NO-1:0][W-1:0]   out_data_o;
  logic [NO-1:0]          out_stop_i = '0;

  logic [N_IN-1:0]        drv_v = '0;
  logic [N_IN-1:0][W-1:0] drv_d = '0;
  logic [NO-1:0]          drv_s = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] inq [N_IN][$];
  logic [W-1:0] expq[NO][$];
  logic [W-1:0] acc_m = '0;
  int acc_in [N_IN];
  int out_cnt[NO];
  int n_sets = 0;
  logic [NO-1:0]        prev_hold = '0;
  logic [NO-1:0][W-1:0] prev_data = '0;
  int streak = 0, best_streak = 0;

  always #2 clk_i = ~clk_i;

  li_shell_wrapper #(.N_IN(N_IN), .W(W)) i_li_shell_wrapper (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_stop_o,
    .out_valid_o, .out_data_o, .out_stop_i
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    in_valid_i = drv_v;
    in_data_i  = drv_d;
    out_stop_i = drv_s;
    #1;
    // R7 persistence across the edge just passed
    for (int j = 0; j < NO; j++) begin
      if (prev_hold[j]) begin
        check(out_valid_o[j] == 1'b1, "R7 valid held", int'(out_valid_o[j]), 1);
        check(out_data_o[j] == prev_data[j], "R7 data held", int'(out_data_o[j]), int'(prev_data[j]));
      end
      prev_hold[j] = out_valid_o[j] & out_stop_i[j];
      prev_data[j] = out_data_o[j];
    end
    for (int i = 0; i < N_IN; i++)
      if (in_valid_i[i] && !in_stop_o[i]) begin
        inq[i].push_back(in_data_i[i]);
        acc_in[i]++;
      end
    forever begin
      logic [W-1:0] s, x;
      bit all_ok = 1;
      for (int i = 0; i < N_IN; i++) if (inq[i].size() == 0) all_ok = 0;
      if (!all_ok) break;
      s = acc_m; x = '0;
      for (int i = 0; i < N_IN; i++) begin
        logic [W-1:0] w;
        w = inq[i].pop_front();
        s = s + w;
        x = x ^ w;
      end
      acc_m = s;
      expq[0].push_back(s);
      expq[1].push_back(x);
      n_sets++;
    end
    for (int j = 0; j < NO; j++)
      if (out_valid_o[j] && !out_stop_i[j]) begin
        out_cnt[j]++;
        if (expq[j].size() == 0) check(0, "R8 unexpected word", int'(out_data_o[j]), -1);
        else begin
          logic [W-1:0] e;
          e = expq[j].pop_front();
          check(out_data_o[j] == e, (j == 0) ? "R4/R8 sum stream" : "R4/R8 xor stream",
                int'(out_data_o[j]), int'(e));
        end
      end
    if (&out_valid_o && out_stop_i == '0) begin
      streak++;
      if (streak > best_streak) best_streak = streak;
    end else streak = 0;
  endtask

  initial begin
    for (int i = 0; i < N_IN; i++) acc_in[i] = 0;
    for (int j = 0; j < NO; j++) out_cnt[j] = 0;
    void'($urandom(32'h5eed));
    #1;
    // R1: reset state
    check(out_valid_o == '0, "R1 out_valid in reset", int'(out_valid_o), 0);
    check(in_stop_o == '0, "R1 in_stop in reset", int'(in_stop_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) step();
    check(out_valid_o == '0, "R1 out_valid after reset", int'(out_valid_o), 0);

    // R2/R3: one channel alone fills its buffer and nothing fires
    drv_v = 2'b01; drv_d = {8'h00, 8'h11};
    repeat (4) step();
    check(acc_in[0] == 2, "R2 words taken by lone channel", acc_in[0], 2);
    check(in_stop_o == 2'b01, "R2 stop at two words", int'(in_stop_o), 1);
    check(out_valid_o == '0, "R3 no result from lone channel", int'(out_valid_o), 0);

    // R9: full streaming
    drv_v = '1;
    for (int c = 0; c < 30; c++) begin
      drv_d = {8'(c * 7 + 3), 8'(c * 13 + 200)};
      step();
    end
    drv_v = '0;
    repeat (12) step();
    check(best_streak >= 20, "R9 one result per cycle", best_streak, 20);

    // R5/R6: output 0 blocked, output 1 free
    begin
      int a0, a1, o1;
      a0 = acc_in[0]; a1 = acc_in[1]; o1 = out_cnt[1];
      drv_v = '1; drv_s = 2'b01; drv_d = {8'hF0, 8'h0F};
      repeat (20) step();
      check(acc_in[0] - a0 == 4, "R6 input 0 words while blocked", acc_in[0] - a0, 4);
      check(acc_in[1] - a1 == 4, "R6 input 1 words while blocked", acc_in[1] - a1, 4);
      check(out_cnt[1] - o1 == 2, "R5/R6 results on free output", out_cnt[1] - o1, 2);
      check(in_stop_o == '1, "R6 all inputs stopped", int'(in_stop_o), 3);
    end
    drv_v = '0; drv_s = '0;
    repeat (15) step();

    // R8: random gaps and stops, with wrapping values
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N_IN; i++) begin
        drv_v[i] = ($urandom % 4) != 0;
        drv_d[i] = 8'($urandom);
      end
      for (int j = 0; j < NO; j++) drv_s[j] = ($urandom % 3) == 0;
      step();
    end
    drv_v = '0; drv_s = '0;
    repeat (30) step();
    check(expq[0].size() == 0, "R8 sum stream drained", expq[0].size(), 0);
    check(expq[1].size() == 0, "R8 xor stream drained", expq[1].size(), 0);
    check(out_cnt[0] == n_sets, "R8 result count", out_cnt[0], n_sets);
    check(out_cnt[1] == n_sets, "R8 result count ch1", out_cnt[1], n_sets);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule